// File: doc/BRIEF.md
# PFC Start-up and Protection Sequencer

This block controls the power-up of a boost power-factor-correction stage and watches over it once it is running. At power-up the bypass relay is open, so the bus capacitors charge through the inrush limiter. When the digitized bus voltage rises above 100 V, the relay closes. The sequencer then counts a settling delay of 100 millisecond ticks. After that delay it enables switching and raises the bus-voltage reference in steps until it reaches 385 V. The outer voltage loop, the current loop and the PWM generation are outside this block. They read the reference and the switching enable.

While running, the block stops switching when the bus reaches the burst upper level and restarts it at the lower level, but only if the light-load input is high. An input over-current, a bus over-voltage, or a precharge that never reaches the relay threshold forces a protection state. The block stays in that state until the bias reset `rstN` is asserted. In the protection state, switching stops, the relay opens and the reference drops to zero.

Bus voltage is 1 V per LSB. Input current is 0.1 A per LSB. `msTick` is a single-cycle pulse once per millisecond.

Top module: `pfc_startup_seq`

## Requirements
- R1: While `rstN` is low and on the first cycle after it is released, `relayOn`, `pwmEn`, `runStat` and `faultStat` are 0, `vRef` is 0 and `burstGate` is 1.
- R2: In precharge, the relay closes (`relayOn`=1) one cycle after `busVolt` is sampled strictly above 100. A value of exactly 100 leaves the relay open.
- R3: After relay closure, `pwmEn` stays 0 for the first 99 ticks. It rises one cycle after the 100th tick, and it is never 1 while `relayOn` is 0.
- R4: When switching is enabled, `vRef` loads the `busVolt` value sampled on that edge, limited to 385. Each later tick in the ramp adds 5 to `vRef`.
- R5: `vRef` never exceeds 385. The last ramp step clamps to exactly 385, `runStat` rises one cycle after `vRef` reaches 385, and `vRef` stays at 385 while `runStat` is 1.
- R6: After relay closure, a `busVolt` sample above 420 gives the fault outputs one cycle later: `faultStat`=1 and `pwmEn`=`relayOn`=`runStat`=0, `vRef`=0. A value of exactly 420 does not trip. The fault state holds until `rstN` is asserted, whatever the inputs do.
- R7: In run with `burstEn`=1, `burstGate` and `pwmEn` drop one cycle after `busVolt` is at least 385. They rise one cycle after `busVolt` is at most 375, and they hold their value in between. With `burstEn`=0, `burstGate`=1 and `pwmEn`=1 in run.
- R8: In any non-fault state, an `inCurr` sample above 120 (12.0 A) gives `faultStat`=1 one cycle later. A value of exactly 120 does not trip.
- R9: If the relay threshold is not crossed within 1000 ticks of precharge, the 1000th tick gives `faultStat`=1 one cycle later. After 999 ticks there is no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low bias reset, the only way to clear a fault |
| msTick | input | 1 | One-cycle pulse per millisecond |
| busVolt | input | 10 | Digitized DC bus voltage, 1 V per LSB |
| inCurr | input | 8 | Digitized input current, 0.1 A per LSB |
| burstEn | input | 1 | Light-load indication that permits burst operation |
| relayOn | output | 1 | Inrush-bypass relay drive |
| pwmEn | output | 1 | Switching enable for the PWM stage |
| vRef | output | 10 | Bus-voltage reference for the voltage loop |
| runStat | output | 1 | High once the reference has reached its rated value |
| faultStat | output | 1 | Latched protection indication |
| burstGate | output | 1 | Burst hysteresis state, 1 when switching is allowed |

## Verification
Every output comes from a register with no combinational path from the inputs. Each result is therefore due exactly one clock after the edge that samples the causing input or tick. The driver changes inputs on the falling edge and lets one rising edge pass. It then queues the expected output set, and the monitor compares that set on the next falling edge. Threshold cases are driven one count before and at the limit: the 99th and 100th settle ticks, the 999th and 1000th precharge ticks, and current and voltage exactly at their limits. This pins the cycle on which each transition occurs.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

  typedef enum logic [2:0] {
    ST_PRECHG,
    ST_SETTLE,
    ST_RAMP,
    ST_RUN,
    ST_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrInc;
    logic refSeed;
    logic refStep;
    logic refClr;
    logic burstArm;
  } dpCmd_t;

  // compare results from datapath to control
  typedef struct packed {
    logic busAboveRelay;
    logic overVolt;
    logic overCurr;
    logic refAtTarget;
  } dpFlags_t;

endpackage

// File: rtl/pfc_seq_ctrl.sv
module pfc_seq_ctrl
  import pfc_seq_pkg::*;
#(
  parameter int SETTLE_MS = 100,
  parameter int PRE_MS    = 1000,
  parameter int TMR_W     = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  dpFlags_t          flags,
  input  logic [TMR_W-1:0]  tmrCnt,
  output dpCmd_t            cmd,
  output seqState_t         state
);

  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_MS - 1);
  localparam logic [TMR_W-1:0] PRE_LAST    = TMR_W'(PRE_MS - 1);

  seqState_t nxtState;

  always_comb begin
    nxtState = state;
    cmd      = '0;
    unique case (state)
      ST_PRECHG: begin
        cmd.tmrInc = msTick;
        cmd.refClr = 1'b1;
        if (flags.overCurr) begin
          nxtState = ST_FAULT;
        end else if (flags.busAboveRelay) begin
          nxtState   = ST_SETTLE;
          cmd.tmrClr = 1'b1;
        end else if (msTick && tmrCnt == PRE_LAST) begin
          nxtState = ST_FAULT;
        end
      end
      ST_SETTLE: begin
        cmd.tmrInc = msTick;
        if (flags.overCurr || flags.overVolt) begin
          nxtState = ST_FAULT;
        end else if (msTick && tmrCnt == SETTLE_LAST) begin
          nxtState    = ST_RAMP;
          cmd.refSeed = 1'b1;
        end
      end
      ST_RAMP: begin
        cmd.refStep = msTick;
        if (flags.overCurr || flags.overVolt) begin
          nxtState = ST_FAULT;
        end else if (flags.refAtTarget) begin
          nxtState = ST_RUN;
        end
      end
      ST_RUN: begin
        cmd.burstArm = 1'b1;
        if (flags.overCurr || flags.overVolt) nxtState = ST_FAULT;
      end
      ST_FAULT: begin
        nxtState = ST_FAULT;
      end
      default: nxtState = ST_FAULT;
    endcase
    if (nxtState == ST_FAULT) begin
      cmd        = '0;
      cmd.refClr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PRECHG;
    else       state <= nxtState;
  end

endmodule

// File: rtl/pfc_seq_dp.sv
module pfc_seq_dp
  import pfc_seq_pkg::*;
#(
  parameter int V_W        = 10,
  parameter int I_W        = 8,
  parameter int TMR_W      = 10,
  parameter int RELAY_ON_V = 100,
  parameter int TARGET_V   = 385,
  parameter int OVP_V      = 420,
  parameter int BURST_LO_V = 375,
  parameter int BURST_HI_V = 385,
  parameter int OCP_LIM    = 120,
  parameter int RAMP_STEP  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [V_W-1:0]   busVolt,
  input  logic [I_W-1:0]   inCurr,
  input  logic             burstEn,
  input  dpCmd_t           cmd,
  output dpFlags_t         flags,
  output logic [TMR_W-1:0] tmrCnt,
  output logic [V_W-1:0]   vRef,
  output logic             burstOk
);

  localparam logic [V_W-1:0] TARGET   = V_W'(TARGET_V);
  localparam logic [V_W:0]   TARGET_X = (V_W+1)'(TARGET_V);
  localparam logic [V_W:0]   STEP_X   = (V_W+1)'(RAMP_STEP);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic [V_W:0]   stepSum;
  logic [V_W-1:0] stepNext;
  logic [V_W-1:0] seedVal;

  always_comb begin
    stepSum  = {1'b0, vRef} + STEP_X;
    stepNext = (stepSum >= TARGET_X) ? TARGET : stepSum[V_W-1:0];
    seedVal  = (busVolt > TARGET) ? TARGET : busVolt;
  end

  always_comb begin
    flags.busAboveRelay = busVolt > V_W'(RELAY_ON_V);
    flags.overVolt      = busVolt > V_W'(OVP_V);
    flags.overCurr      = inCurr > I_W'(OCP_LIM);
    flags.refAtTarget   = vRef == TARGET;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         tmrCnt <= '0;
    else if (cmd.tmrClr)               tmrCnt <= '0;
    else if (cmd.tmrInc && tmrCnt != TMR_MAX) tmrCnt <= tmrCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            vRef <= '0;
    else if (cmd.refClr)  vRef <= '0;
    else if (cmd.refSeed) vRef <= seedVal;
    else if (cmd.refStep) vRef <= stepNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          burstOk <= 1'b1;
    else if (!cmd.burstArm || !burstEn) burstOk <= 1'b1;
    else if (busVolt >= V_W'(BURST_HI_V)) burstOk <= 1'b0;
    else if (busVolt <= V_W'(BURST_LO_V)) burstOk <= 1'b1;
  end

endmodule

// File: rtl/pfc_startup_seq.sv
module pfc_startup_seq
  import pfc_seq_pkg::*;
#(
  parameter int V_W        = 10,
  parameter int I_W        = 8,
  parameter int RELAY_ON_V = 100,
  parameter int TARGET_V   = 385,
  parameter int OVP_V      = 420,
  parameter int BURST_LO_V = 375,
  parameter int BURST_HI_V = 385,
  parameter int OCP_LIM    = 120,
  parameter int RAMP_STEP  = 5,
  parameter int SETTLE_MS  = 100,
  parameter int PRE_MS     = 1000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           msTick,
  input  logic [V_W-1:0] busVolt,
  input  logic [I_W-1:0] inCurr,
  input  logic           burstEn,
  output logic           relayOn,
  output logic           pwmEn,
  output logic [V_W-1:0] vRef,
  output logic           runStat,
  output logic           faultStat,
  output logic           burstGate
);

  localparam int TMR_MAXV = (PRE_MS > SETTLE_MS) ? PRE_MS : SETTLE_MS;
  localparam int TMR_W    = $clog2(TMR_MAXV + 1);

  dpCmd_t           cmd;
  dpFlags_t         flags;
  seqState_t        state;
  logic [TMR_W-1:0] tmrCnt;
  logic             burstOk;

  pfc_seq_ctrl #(
    .SETTLE_MS(SETTLE_MS), .PRE_MS(PRE_MS), .TMR_W(TMR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .flags(flags),
    .tmrCnt(tmrCnt), .cmd(cmd), .state(state)
  );

  pfc_seq_dp #(
    .V_W(V_W), .I_W(I_W), .TMR_W(TMR_W), .RELAY_ON_V(RELAY_ON_V),
    .TARGET_V(TARGET_V), .OVP_V(OVP_V), .BURST_LO_V(BURST_LO_V),
    .BURST_HI_V(BURST_HI_V), .OCP_LIM(OCP_LIM), .RAMP_STEP(RAMP_STEP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .busVolt(busVolt), .inCurr(inCurr),
    .burstEn(burstEn), .cmd(cmd), .flags(flags), .tmrCnt(tmrCnt),
    .vRef(vRef), .burstOk(burstOk)
  );

  always_comb begin
    relayOn   = (state == ST_SETTLE) || (state == ST_RAMP) || (state == ST_RUN);
    pwmEn     = (state == ST_RAMP) || ((state == ST_RUN) && burstOk);
    runStat   = state == ST_RUN;
    faultStat = state == ST_FAULT;
    burstGate = burstOk;
  end

endmodule

// File: rtl/pfc_seq_chk.sv
module pfc_seq_chk #(
  parameter int V_W        = 10,
  parameter int I_W        = 8,
  parameter int RELAY_ON_V = 100,
  parameter int TARGET_V   = 385,
  parameter int OCP_LIM    = 120
) (
  input logic           clk,
  input logic           rstN,
  input logic [V_W-1:0] busVolt,
  input logic [I_W-1:0] inCurr,
  input logic           relayOn,
  input logic           pwmEn,
  input logic [V_W-1:0] vRef,
  input logic           runStat,
  input logic           faultStat
);

  // R6
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStat |=> faultStat);

  // R6
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStat |-> (!pwmEn && !relayOn && !runStat && vRef == '0));

  // R3
  pwm_needs_relay_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwmEn |-> relayOn);

  // R5
  ref_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    vRef <= V_W'(TARGET_V));

  // R5
  run_at_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    runStat |-> vRef == V_W'(TARGET_V));

  // R2
  relay_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(relayOn) |-> $past(busVolt) > V_W'(RELAY_ON_V));

  // R8
  ocp_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCurr > I_W'(OCP_LIM)) |=> faultStat);

endmodule

bind pfc_startup_seq pfc_seq_chk #(
  .V_W(V_W), .I_W(I_W), .RELAY_ON_V(RELAY_ON_V),
  .TARGET_V(TARGET_V), .OCP_LIM(OCP_LIM)
) chk_i (
  .clk(clk), .rstN(rstN), .busVolt(busVolt), .inCurr(inCurr),
  .relayOn(relayOn), .pwmEn(pwmEn), .vRef(vRef),
  .runStat(runStat), .faultStat(faultStat)
);

// File: tb/pfc_startup_seq_tb.sv
`timescale 1ns/1ps
module pfc_startup_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic [9:0] busVolt = '0;
  logic [7:0] inCurr = '0;
  logic       burstEn = 1'b0;
  logic       relayOn, pwmEn, runStat, faultStat, burstGate;
  logic [9:0] vRef;

  always #5 clk = ~clk;

  pfc_startup_seq dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .busVolt(busVolt),
    .inCurr(inCurr), .burstEn(burstEn), .relayOn(relayOn), .pwmEn(pwmEn),
    .vRef(vRef), .runStat(runStat), .faultStat(faultStat),
    .burstGate(burstGate)
  );

  typedef struct packed {
    logic       relay;
    logic       pwm;
    logic [9:0] vref;
    logic       run;
    logic       fault;
    logic       gate;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       nChk = 0;
  int       nFail = 0;
  bit       done = 1'b0;

  // one clock: inputs change on the falling edge, one rising edge passes
  task automatic cyc(input logic t);
    @(negedge clk);
    msTick = t;
    @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string tag, input logic r, input logic p,
                           input int v, input logic rn, input logic f,
                           input logic g);
    expItem_t e;
    e.relay = r; e.pwm = p; e.vref = 10'(v); e.run = rn; e.fault = f; e.gate = g;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    msTick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // monitor: compares queued items at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t e;
        expItem_t a;
        string    t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a.relay = relayOn; a.pwm = pwmEn; a.vref = vRef;
        a.run = runStat; a.fault = faultStat; a.gate = burstGate;
        nChk++;
        if (a !== e) begin
          nFail++;
          $display("FAIL %s: got relay=%b pwm=%b vref=%0d run=%b fault=%b gate=%b, want relay=%b pwm=%b vref=%0d run=%b fault=%b gate=%b",
                   t, a.relay, a.pwm, a.vref, a.run, a.fault, a.gate,
                   e.relay, e.pwm, e.vref, e.run, e.fault, e.gate);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got no end, want end of stimulus");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(0);
    expectOut("R1 reset", 0, 0, 0, 0, 0, 1);

    // R2 threshold not exceeded at exactly 100
    busVolt = 10'd100;
    cyc(0); cyc(1);
    expectOut("R2 at threshold", 0, 0, 0, 0, 0, 1);

    // R8 current exactly at limit
    inCurr = 8'd120;
    cyc(0);
    expectOut("R8 at limit", 0, 0, 0, 0, 0, 1);
    inCurr = 8'd0;

    // R2 relay closes
    busVolt = 10'd302;
    cyc(0);
    expectOut("R2 close", 1, 0, 0, 0, 0, 1);

    // R3 settle window
    for (int k = 0; k < 99; k++) cyc(1);
    cyc(0);
    expectOut("R3 before 100th tick", 1, 0, 0, 0, 0, 1);
    cyc(1);
    expectOut("R3 R4 enable and seed", 1, 1, 302, 0, 0, 1);

    // R4 ramp steps
    for (int k = 0; k < 15; k++) cyc(1);
    cyc(0);
    expectOut("R4 step 15", 1, 1, 377, 0, 0, 1);
    cyc(1);
    expectOut("R4 step 16", 1, 1, 382, 0, 0, 1);
    cyc(1);
    expectOut("R5 clamp", 1, 1, 385, 0, 0, 1);
    cyc(0);
    expectOut("R5 run", 1, 1, 385, 1, 0, 1);
    cyc(1);
    expectOut("R5 hold", 1, 1, 385, 1, 0, 1);

    // R7 burst hysteresis
    burstEn = 1'b1;
    busVolt = 10'd380;
    cyc(0);
    expectOut("R7 mid band", 1, 1, 385, 1, 0, 1);
    busVolt = 10'd385;
    cyc(0);
    expectOut("R7 upper stop", 1, 0, 385, 1, 0, 0);
    busVolt = 10'd376;
    cyc(0);
    expectOut("R7 hold off", 1, 0, 385, 1, 0, 0);
    busVolt = 10'd375;
    cyc(0);
    expectOut("R7 lower resume", 1, 1, 385, 1, 0, 1);
    busVolt = 10'd390;
    cyc(0);
    expectOut("R7 stop again", 1, 0, 385, 1, 0, 0);
    burstEn = 1'b0;
    cyc(0);
    expectOut("R7 burst disabled", 1, 1, 385, 1, 0, 1);

    // R6 over-voltage
    busVolt = 10'd420;
    cyc(0);
    expectOut("R6 at limit", 1, 1, 385, 1, 0, 1);
    busVolt = 10'd421;
    cyc(0);
    expectOut("R6 trip", 0, 0, 0, 0, 1, 1);
    busVolt = 10'd380;
    for (int k = 0; k < 5; k++) cyc(1);
    expectOut("R6 latched", 0, 0, 0, 0, 1, 1);

    // R8 over-current during precharge
    inCurr = 8'd121;
    busVolt = 10'd50;
    doReset();
    cyc(0);
    expectOut("R8 trip", 0, 0, 0, 0, 1, 1);
    inCurr = 8'd0;
    cyc(0);
    expectOut("R8 latched", 0, 0, 0, 0, 1, 1);

    // R9 precharge timeout
    doReset();
    for (int k = 0; k < 999; k++) cyc(1);
    cyc(0);
    expectOut("R9 before timeout", 0, 0, 0, 0, 0, 1);
    cyc(1);
    expectOut("R9 timeout", 0, 0, 0, 0, 1, 1);

    repeat (3) cyc(0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule